// File: doc/BRIEF.md
# Four-Level Priority Arbiter with Aging and Starvation Masking

This block decides which of N initiators owns a shared target. Every requester presents a small priority code. A programmable table turns that code into one of four arbitration levels. The highest level that has requests wins. Inside that level a single rotating pointer picks the next requester after the previous winner. A per-initiator weight lets the current owner keep the grant for several decisions in a row before the pointer moves on.

Two mechanisms protect requesters that have been waiting. First, an age counter per initiator lifts a waiting requester one level once its counter reaches a programmable threshold. Second, a streak counter tracks consecutive grants given at one level. When the streak reaches a programmable count, the next decision skips that level, provided some lower level is requesting.

A grant is held until the target signals `accept`. The arbiter then decides again. The control is a two-state machine:
- `ST_IDLE` means no grant is driven. The transition IDLE→BUSY happens on any request.
- `ST_BUSY` drives the grant. Its transitions are:
  - BUSY→BUSY (hold): `accept` is low.
  - BUSY→BUSY (re-arbitrate): `accept` is high and requests are present.
  - BUSY→IDLE: `accept` is high and no requests are present.

Top module: `prio_lvl_arbiter`

## Requirements
- R1: While reset is asserted and after its release with no requests, `gnt` is all zeros and `gnt_valid` is 0.
- R2: A decision happens at each rising edge where the block is idle or `accept` is high. Its result appears on `gnt` (one-hot), `gnt_idx` and `gnt_valid` right after that edge. While `accept` is low, the grant and index stay unchanged.
- R3: A decision taken with no requests present drops `gnt_valid` and clears `gnt`.
- R4: The level of prio code p is `cfg_map[2p+1:2p]`, where 3 is the highest level. Only requesters at the highest requesting level are candidates.
- R5: Among the candidates, the winner is the first one found scanning upward cyclically from the previous winner plus one.
- R6: The previous winner wins again only while it is a candidate and its count of back-to-back grants is below its weight. The weight of initiator i is `cfg_weight[WW*i +: WW]`, and a weight of 0 acts as 1.
- R7: After reset the previous-winner pointer is initiator 0 with zero grants spent, so initiator 0 wins the first decision if it is a candidate.
- R8: The age counter of a requester counts up at each decision it loses, up to `cfg_age_thr`. The counter clears when the initiator is granted or stops requesting. At or above a nonzero threshold, the requester's level rises by one, saturating at 3. A threshold of 0 disables aging.
- R9: A streak counter counts consecutive grants at the same level. When `cfg_mask_cnt` is nonzero and the streak is at or above it, the next decision excludes that level if any lower level is requesting.
- R10: The prio code of initiator i is `req_prio[PW*i +: PW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N | Request per initiator |
| req_prio | input | N*PW | Priority code per initiator |
| accept | input | 1 | Current grant's transfer accepted; allows a new decision |
| cfg_map | input | 2*2^PW | Code-to-level table, two bits per code |
| cfg_weight | input | N*WW | Back-to-back grant weight per initiator |
| cfg_age_thr | input | AW | Aging threshold (0 disables) |
| cfg_mask_cnt | input | SW | Streak length that triggers level masking (0 disables) |
| gnt | output | N | One-hot grant |
| gnt_valid | output | 1 | A grant is driven |
| gnt_idx | output | clog2(N) | Index of the granted initiator |

## Verification
A decision made at rising edge k shows on the outputs immediately after edge k and nowhere earlier. Aging and streak effects take hold one decision after the grant that completes them. The bench drives inputs at the falling edge and advances its requirement model for the coming rising edge. It then compares the outputs at the following falling edge, so each result is checked exactly one edge after its stimulus. Directed sequences with hand-derived winner orders cover mapping, rotation, weights, aging and masking. Seeded random traffic under random configurations covers the rest.

// File: rtl/pla_pkg.sv
package pla_pkg;
    typedef enum logic {ST_IDLE, ST_BUSY} arb_state_e;
    typedef logic [1:0] lvl_t;
    localparam int unsigned NUM_LVL = 4;
endpackage

// File: rtl/pla_level_map.sv
module pla_level_map
    import pla_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int AW = 4,
    parameter int IW = 3,
    localparam int MAPW = (1 << PW) * 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] req_prio,
    input  logic [MAPW-1:0] cfg_map,
    input  logic [AW-1:0]   cfg_age_thr,
    input  logic            arb_en,
    input  logic            win_any,
    input  logic [IW-1:0]   win_idx,
    output logic [2*N-1:0]  eff_lvl
);
    for (genvar g = 0; g < N; g++) begin : g_init
        logic [AW-1:0] age_q;
        logic [PW-1:0] code;
        lvl_t          base;
        logic          aged;

        assign code = req_prio[g*PW +: PW];
        assign base = cfg_map[2*int'(code) +: 2];
        assign aged = (cfg_age_thr != '0) && (age_q >= cfg_age_thr);
        assign eff_lvl[2*g +: 2] = (aged && base != 2'd3) ? base + 2'd1 : base;

        // R8: wait counter per initiator
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q <= '0;
            end else if (!req[g]) begin
                age_q <= '0;
            end else if (arb_en && win_any && win_idx == IW'(g)) begin
                age_q <= '0;
            end else if (arb_en && age_q < cfg_age_thr) begin
                age_q <= age_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pla_pick.sv
module pla_pick
    import pla_pkg::*;
#(
    parameter int N  = 8,
    parameter int WW = 3,
    parameter int IW = 3
) (
    input  logic [N-1:0]    req,
    input  logic [2*N-1:0]  eff_lvl,
    input  logic [N*WW-1:0] cfg_weight,
    input  logic [IW-1:0]   last_idx,
    input  logic [WW-1:0]   burst,
    input  logic            mask_on,
    input  lvl_t            mask_lvl,
    output logic            win_any,
    output logic [IW-1:0]   win_idx,
    output lvl_t            win_lvl
);
    logic [NUM_LVL-1:0] has;
    logic [N-1:0]       cand;
    logic               lower, excl, found;
    logic [WW-1:0]      w_eff;
    int                 idx;

    always_comb begin
        has = '0;
        for (int i = 0; i < N; i++)
            if (req[i]) has[eff_lvl[2*i +: 2]] = 1'b1;

        // R9: lower levels waiting?
        lower = 1'b0;
        for (int l = 0; l < NUM_LVL; l++)
            if (l < int'(mask_lvl) && has[l]) lower = 1'b1;
        excl = mask_on && lower;

        // R4: highest non-excluded level
        win_any = 1'b0;
        win_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++)
            if (has[l] && !(excl && l == int'(mask_lvl))) begin
                win_any = 1'b1;
                win_lvl = lvl_t'(l);
            end

        for (int i = 0; i < N; i++)
            cand[i] = req[i] && (eff_lvl[2*i +: 2] == win_lvl);

        // R6: weighted hold, R5: rotate
        w_eff = cfg_weight[int'(last_idx)*WW +: WW];
        if (w_eff == '0) w_eff = WW'(1);
        win_idx = last_idx;
        found   = cand[last_idx] && (burst < w_eff);
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last_idx) + k) % N;
            if (!found && cand[idx]) begin
                win_idx = IW'(idx);
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_lvl_arbiter.sv
module prio_lvl_arbiter
    import pla_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int WW = 3,
    parameter int AW = 4,
    parameter int SW = 4,
    localparam int IW   = (N > 1) ? $clog2(N) : 1,
    localparam int MAPW = (1 << PW) * 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] req_prio,
    input  logic            accept,
    input  logic [MAPW-1:0] cfg_map,
    input  logic [N*WW-1:0] cfg_weight,
    input  logic [AW-1:0]   cfg_age_thr,
    input  logic [SW-1:0]   cfg_mask_cnt,
    output logic [N-1:0]    gnt,
    output logic            gnt_valid,
    output logic [IW-1:0]   gnt_idx
);
    localparam logic [WW-1:0] BMAX = '1;
    localparam logic [SW-1:0] SMAX = '1;

    arb_state_e    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [WW-1:0] burst_q;
    lvl_t          lvl_q;
    logic [SW-1:0] streak_q;
    logic          arb_en, mask_on, win_any;
    logic [IW-1:0] win_idx;
    lvl_t          win_lvl;
    logic [2*N-1:0] eff_lvl;

    assign arb_en  = (state_q == ST_IDLE) || accept;
    assign mask_on = (cfg_mask_cnt != '0) && (streak_q >= cfg_mask_cnt);

    pla_level_map #(.N(N), .PW(PW), .AW(AW), .IW(IW)) u_map (
        .clk(clk), .rst_n(rst_n), .req(req), .req_prio(req_prio),
        .cfg_map(cfg_map), .cfg_age_thr(cfg_age_thr), .arb_en(arb_en),
        .win_any(win_any), .win_idx(win_idx), .eff_lvl(eff_lvl)
    );

    pla_pick #(.N(N), .WW(WW), .IW(IW)) u_pick (
        .req(req), .eff_lvl(eff_lvl), .cfg_weight(cfg_weight),
        .last_idx(idx_q), .burst(burst_q), .mask_on(mask_on),
        .mask_lvl(lvl_q), .win_any(win_any), .win_idx(win_idx),
        .win_lvl(win_lvl)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_any) state_d = ST_BUSY;
            ST_BUSY: if (accept && !win_any) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R6, R7, R9: pointer, burst and streak bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            burst_q  <= '0;
            lvl_q    <= '0;
            streak_q <= '0;
        end else if (arb_en && win_any) begin
            idx_q    <= win_idx;
            burst_q  <= (win_idx == idx_q) ? ((burst_q == BMAX) ? burst_q : burst_q + 1'b1) : WW'(1);
            lvl_q    <= win_lvl;
            streak_q <= (win_lvl == lvl_q) ? ((streak_q == SMAX) ? streak_q : streak_q + 1'b1) : SW'(1);
        end
    end

    always_comb begin
        gnt_idx = idx_q;
        unique case (state_q)
            ST_IDLE: begin gnt = '0;                 gnt_valid = 1'b0; end
            ST_BUSY: begin gnt = N'(1) << idx_q;     gnt_valid = 1'b1; end
            default: begin gnt = '0;                 gnt_valid = 1'b0; end
        endcase
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($onehot(gnt) && gnt[gnt_idx]));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !accept) |=> (gnt_valid && $stable(gnt_idx)));
    a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((!gnt_valid || accept) && req == '0) |=> !gnt_valid);
    a_r2_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((!gnt_valid || accept) && req != '0) |=> (gnt_valid && |($past(req) & gnt)));
endmodule

// File: tb/tb_prio_lvl_arbiter.sv
`timescale 1ns/100ps
module tb_prio_lvl_arbiter;
    localparam int N = 8, PW = 3, WW = 3, AW = 4, SW = 4, IW = 3;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] req = '0;
    logic [N*PW-1:0] req_prio = '0;
    logic accept = 0;
    logic [15:0] cfg_map = 16'hFA50;
    logic [N*WW-1:0] cfg_weight = 24'h249249;
    logic [AW-1:0] cfg_age_thr = '0;
    logic [SW-1:0] cfg_mask_cnt = '0;
    logic [N-1:0] gnt;
    logic gnt_valid;
    logic [IW-1:0] gnt_idx;

    int checks = 0, errors = 0, cyc = 0;
    int m_busy = 0, m_idx = 0, m_burst = 0, m_lvl = 0, m_streak = 0;
    int m_cnt[N];

    always #2.5 clk = ~clk;

    prio_lvl_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_prio(req_prio), .accept(accept),
        .cfg_map(cfg_map), .cfg_weight(cfg_weight), .cfg_age_thr(cfg_age_thr),
        .cfg_mask_cnt(cfg_mask_cnt), .gnt(gnt), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    function automatic int lvl_of(int i);
        int p, b;
        p = int'((req_prio >> (PW*i)) & 3'h7);
        b = int'((cfg_map >> (2*p)) & 16'h3);
        if (cfg_age_thr != 0 && m_cnt[i] >= int'(cfg_age_thr) && b < 3) b++;
        return b;
    endfunction

    task automatic model_step();
        int lv[N];
        bit has[4];
        bit arb, lower, excl;
        int top, w, win;
        arb = (m_busy == 0) || accept;
        for (int l = 0; l < 4; l++) has[l] = 0;
        for (int i = 0; i < N; i++) begin
            lv[i] = lvl_of(i);
            if (req[i]) has[lv[i]] = 1;
        end
        lower = 0;
        for (int l = 0; l < m_lvl; l++) if (has[l]) lower = 1;
        excl = (cfg_mask_cnt != 0) && (m_streak >= int'(cfg_mask_cnt)) && lower;
        top = -1;
        for (int l = 3; l >= 0; l--)
            if (top < 0 && has[l] && !(excl && l == m_lvl)) top = l;
        win = -1;
        if (arb && top >= 0) begin
            w = int'((cfg_weight >> (WW*m_idx)) & 3'h7);
            if (w == 0) w = 1;
            if (req[m_idx] && lv[m_idx] == top && m_burst < w) win = m_idx;
            else
                for (int k = 1; k <= N; k++)
                    if (win < 0 && req[(m_idx+k)%N] && lv[(m_idx+k)%N] == top) win = (m_idx+k)%N;
        end
        for (int i = 0; i < N; i++) begin
            if (!req[i]) m_cnt[i] = 0;
            else if (arb && win == i) m_cnt[i] = 0;
            else if (arb && m_cnt[i] < int'(cfg_age_thr)) m_cnt[i]++;
        end
        if (arb) begin
            if (win < 0) m_busy = 0;
            else begin
                m_burst  = (win == m_idx) ? ((m_burst < 7) ? m_burst + 1 : 7) : 1;
                m_streak = (top == m_lvl) ? ((m_streak < 15) ? m_streak + 1 : 15) : 1;
                m_lvl = top; m_idx = win; m_busy = 1;
            end
        end
    endtask

    task automatic check_out(string tag);
        logic [N-1:0] eg;
        eg = (m_busy != 0) ? (N'(1) << m_idx) : '0;
        checks++;
        if (gnt_valid !== (m_busy != 0) || gnt !== eg || (m_busy != 0 && int'(gnt_idx) != m_idx)) begin
            errors++;
            $display("FAIL %s: gnt=%b valid=%0d idx=%0d expected gnt=%b valid=%0d idx=%0d",
                     tag, gnt, gnt_valid, gnt_idx, eg, m_busy, m_idx);
        end
    endtask

    task automatic expect_idx(string tag, int e);
        checks++;
        if (gnt_valid !== 1'b1 || int'(gnt_idx) != e) begin
            errors++;
            $display("FAIL %s: valid=%0d idx=%0d expected valid=1 idx=%0d", tag, gnt_valid, gnt_idx, e);
        end
    endtask

    task automatic cycle(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic set_all_prio(int p);
        for (int i = 0; i < N; i++) req_prio[PW*i +: PW] = PW'(p);
    endtask

    task automatic run_rand(string tag, int n, int dens, int acc);
        for (int c = 0; c < n; c++) begin
            for (int i = 0; i < N; i++) begin
                req[i] = ($urandom % 100) < dens;
                req_prio[PW*i +: PW] = PW'($urandom);
            end
            accept = ($urandom % 100) < acc;
            cycle(tag);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int n6;
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        check_out("R1 in reset");
        rst_n = 1;
        cycle("R1 after release");

        // R7: first decision favours initiator 0
        req = 8'hFF; set_all_prio(0); accept = 1;
        cycle("R7"); expect_idx("R7 first winner", 0);
        cycle("R5"); expect_idx("R5 rotate", 1);
        cycle("R5"); expect_idx("R5 rotate", 2);
        // R2: hold without accept
        accept = 0;
        for (int c = 0; c < 3; c++) begin cycle("R2 hold"); expect_idx("R2 hold", 2); end
        // R4 / R10: level mapping and field position
        accept = 1; req = 8'h81; req_prio[PW*0 +: PW] = 3'd0; req_prio[PW*7 +: PW] = 3'd6;
        cycle("R4 R10"); expect_idx("R4 R10 top level", 7);
        cycle("R4"); expect_idx("R4 sole top", 7);
        // R5: rotation from 7
        req = 8'hFF; set_all_prio(0);
        for (int e = 0; e < 4; e++) begin cycle("R5"); expect_idx("R5 rotation", e); end
        // R6: weights 3 on initiator 2, 0 on initiator 5
        cfg_weight[WW*2 +: WW] = 3'd3; cfg_weight[WW*5 +: WW] = 3'd0; req = 8'h24;
        cycle("R6"); expect_idx("R6 weight0 as 1", 5);
        for (int c = 0; c < 3; c++) begin cycle("R6"); expect_idx("R6 weight 3", 2); end
        cycle("R6"); expect_idx("R6 move on", 5);
        cycle("R6"); expect_idx("R6 back", 2);
        // R3: no requests drops grant
        req = '0;
        cycle("R3"); checks++;
        if (gnt_valid !== 1'b0 || gnt !== '0) begin
            errors++; $display("FAIL R3: valid=%0d gnt=%b expected 0", gnt_valid, gnt);
        end
        // R8: aging lifts initiator 0 from level 1 to 2
        cfg_weight = 24'h249249; cfg_age_thr = 4'd3;
        req = 8'h07; req_prio[PW*0 +: PW] = 3'd2; req_prio[PW*1 +: PW] = 3'd4; req_prio[PW*2 +: PW] = 3'd4;
        cycle("R8"); expect_idx("R8 wait1", 1);
        cycle("R8"); expect_idx("R8 wait2", 2);
        cycle("R8"); expect_idx("R8 wait3", 1);
        cycle("R8"); expect_idx("R8 aged competes", 2);
        cycle("R8"); expect_idx("R8 aged wins", 0);
        // R9: masking lets level 0 through
        cfg_age_thr = 0; cfg_mask_cnt = 4'd2; cfg_weight[WW*1 +: WW] = 3'd7;
        req = 8'h42; req_prio[PW*1 +: PW] = 3'd7; req_prio[PW*6 +: PW] = 3'd0;
        n6 = 0;
        for (int c = 0; c < 12; c++) begin
            cycle("R9");
            if (gnt_valid && gnt_idx == 3'd6) n6++;
        end
        checks++;
        if (n6 < 3) begin errors++; $display("FAIL R9: low level grants=%0d expected >=3", n6); end

        // random traffic under random configurations
        for (int ph = 0; ph < 4; ph++) begin
            cfg_map = 16'($urandom); cfg_weight = 24'($urandom);
            cfg_age_thr = AW'($urandom % 6); cfg_mask_cnt = SW'($urandom % 5);
            run_rand("R2 R4 R5 R6 R8 R9 random", 2500, 20 + 20*ph, 40 + 15*ph);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule